// File: doc/BRIEF.md
# DRAM Refresh Row Counter and Request Logic

This block supplies the refresh half of a dynamic RAM controller. It holds the row address for the next refresh cycle. It watches a slow periodic refresh clock. When one of that clock's high phases goes by with no refresh completed, it raises a refresh request. A refresh cycle starts when the controller pulses a start input. The block then reports refresh-active for a fixed number of system clocks. During those cycles it enables every row-strobe output and presents its row address for the address multiplexer. When the cycle completes, the row address steps on by one.

The request leaves the block on a shared open-drain line. The block only ever pulls the line low, through an output enable. It reads the line's level back on a separate input. Any other agent on the board may also pull the line low. When the line is seen low while the block itself is not pulling it, the row counter returns to zero. The block's own request therefore never clears its counter. Refresh does not depend on chip select, and the block has no chip-select input. All inputs are synchronous to `clk`.

Top module: `rfsh_ctrl`

## Requirements
- R1: After reset the row address is 0, the request line is not pulled, refresh-active is 0 and all row-strobe enables are 0.
- R2: When `ref_go_i` is sampled high while idle, refresh-active and all `NUM_RAS` strobe enables read 1 for exactly `REF_CYCLES` clock cycles, starting at the next edge. Throughout that time `row_addr_o` holds the row being refreshed.
- R3: Each completed refresh cycle adds one to the row address at the edge that ends the cycle. The step from 1023 (all ones) goes to 0.
- R4: If no refresh completed while the refresh clock was high, the block pulls the request line (`rfi_oe_o` = 1) from the first system-clock edge at which `rfck_i` is sampled low after being sampled high.
- R5: If a refresh completed while the refresh clock was high, the following fall of the refresh clock raises no request.
- R6: A pending request is withdrawn (`rfi_oe_o` = 0) at the edge where a refresh cycle completes.
- R7: If the line reads low (`rfi_in_i` = 0) while `rfi_oe_o` = 0, the row address is 0 after the next edge.
- R8: If the line reads low only because the block itself pulls it (`rfi_oe_o` = 1), the row address is unchanged.
- R9: `ref_go_i` has no effect while a refresh cycle is running. The cycle keeps its length, and the row advances only once.
- R10: If an external clear and a refresh completion fall on the same edge, the clear wins and the row address becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfck_i | input | 1 | Periodic refresh clock, sampled on `clk` |
| ref_go_i | input | 1 | Start a refresh cycle (taken only when idle) |
| rfi_in_i | input | 1 | Level read back from the shared request line |
| rfi_oe_o | output | 1 | Pull the shared request line low (request active) |
| ref_active_o | output | 1 | Refresh cycle in progress, to the strobe logic |
| ras_en_o | output | NUM_RAS | Row-strobe enables, all high during refresh |
| row_addr_o | output | ROW_W | Refresh row address for the address multiplexer |

## Verification
Every result appears exactly one clock edge after the stimulus that causes it. This covers a start pulse raising refresh-active, a sampled fall of the refresh clock raising the request, and a low line clearing the row. The exception is the end of a refresh: the row step and the withdrawal of the request come `REF_CYCLES` edges after the edge that took the start. The bench changes inputs on the falling clock edge and reads outputs 1 ns after the rising edge. It counts edges from the edge that took each stimulus, so every sample lands in the cycle the requirement names. The bench also samples one cycle before each due edge, to show that no result arrives early.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int ROW_W_DEF      = 10;
  localparam int NUM_RAS_DEF    = 4;
  localparam int REF_CYCLES_DEF = 4;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;
endpackage

// File: rtl/rfsh_edge.sv
module rfsh_edge
  import rfsh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sig_i,
  output logic      level_q_o,
  output edge_evt_t evt_o
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign level_q_o  = sig_q;
  assign evt_o.rise = !sig_q && sig_i;
  assign evt_o.fall = sig_q && !sig_i;
endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic busy_o,
  output logic done_o
);
  localparam int TW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(CYC - 1);

  logic          busy_q;
  logic [TW-1:0] left_q;

  assign done_o = busy_q && (left_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        left_q <= LAST;
      end
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else begin
      left_q <= left_q - 1'b1;
    end
  end

  // R9: a start seen mid-cycle must not re-arm the timer
  p_no_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done_o |=> busy_q && (left_q == $past(left_q) - 1'b1));
  // R2: a start taken while idle opens a cycle
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && go_i |=> busy_q && (left_q == LAST));
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o
);
  localparam logic [ROW_W-1:0] ROW_MAX = '1;

  function automatic logic [ROW_W-1:0] row_next(input logic [ROW_W-1:0] r);
    return (r == ROW_MAX) ? '0 : r + 1'b1;
  endfunction

  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      row_q <= '0;
    else if (clr_i)  row_q <= '0;
    else if (step_i) row_q <= row_next(row_q);
  end

  assign row_o = row_q;

  // R3: the all-ones row rolls over to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !clr_i && (row_q == ROW_MAX) |=> row_q == '0);
  // R10: a clear wins over a step on the same edge
  p_clr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && step_i |=> row_q == '0);
endmodule

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
#(
  parameter int ROW_W      = ROW_W_DEF,
  parameter int NUM_RAS    = NUM_RAS_DEF,
  parameter int REF_CYCLES = REF_CYCLES_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rfck_i,
  input  logic               ref_go_i,
  input  logic               rfi_in_i,
  output logic               rfi_oe_o,
  output logic               ref_active_o,
  output logic [NUM_RAS-1:0] ras_en_o,
  output logic [ROW_W-1:0]   row_addr_o
);
  edge_evt_t rfck_evt;
  logic      rfck_hi_q;
  logic      busy;
  logic      done_evt;
  logic      ext_clr;
  logic      done_hi_q;
  logic      req_q;

  rfsh_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_i     (rfck_i),
    .level_q_o (rfck_hi_q),
    .evt_o     (rfck_evt)
  );

  rfsh_timer #(.CYC(REF_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (ref_go_i),
    .busy_o (busy),
    .done_o (done_evt)
  );

  // A low line is taken as a clear only while the block is not pulling it
  assign ext_clr = !rfi_in_i && !req_q;

  rfsh_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ext_clr),
    .step_i (done_evt),
    .row_o  (row_addr_o)
  );

  // Remembers whether a refresh finished during the current high phase
  always_ff @(posedge clk) begin
    if (!rst_n)                       done_hi_q <= 1'b0;
    else if (rfck_evt.rise)           done_hi_q <= 1'b0;
    else if (done_evt && rfck_hi_q)   done_hi_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               req_q <= 1'b0;
    else if (done_evt)                        req_q <= 1'b0;
    else if (rfck_evt.fall && !done_hi_q)     req_q <= 1'b1;
  end

  assign rfi_oe_o     = req_q;
  assign ref_active_o = busy;
  assign ras_en_o     = {NUM_RAS{busy}};

  // R4: a missed high phase raises the request at the sampled fall
  p_req_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rfck_evt.fall && !done_hi_q && !done_evt |=> rfi_oe_o);
  // R5: a serviced high phase raises nothing new
  p_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rfck_evt.fall && done_hi_q && !rfi_oe_o |=> !rfi_oe_o);
  // R6: completion withdraws the request
  p_done_drops_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !rfi_oe_o);
  // R7: an external low clears the row
  p_ext_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rfi_in_i && !rfi_oe_o |=> row_addr_o == '0);
  // R8: the block's own pull leaves the row alone
  p_own_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rfi_oe_o && !done_evt |=> $stable(row_addr_o));
  // R2: every strobe enable is high while refreshing
  p_ras_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_active_o |-> (ras_en_o == {NUM_RAS{1'b1}}));
endmodule

// File: tb/rfsh_ctrl_bench.sv
module rfsh_ctrl_bench;
  localparam int ROW_W = 10;
  localparam int NRAS  = 4;
  localparam int RC    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rfck = 1'b0;
  logic go = 1'b0;
  logic ext_low = 1'b0;
  logic oe, active;
  logic [NRAS-1:0]  ras;
  logic [ROW_W-1:0] row;
  logic line;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // open-drain line with pull-up
  assign line = !(oe || ext_low);

  rfsh_ctrl #(.ROW_W(ROW_W), .NUM_RAS(NRAS), .REF_CYCLES(RC)) u_rfsh_ctrl (
    .clk(clk), .rst_n(rst_n), .rfck_i(rfck), .ref_go_i(go),
    .rfi_in_i(line), .rfi_oe_o(oe), .ref_active_o(active),
    .ras_en_o(ras), .row_addr_o(row)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse start, return 1 ns after the edge that ends the cycle
  task automatic refresh_once();
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    repeat (RC) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 row", int'(row), 0);
    chk("R1 oe", int'(oe), 0);
    chk("R1 active", int'(active), 0);
    chk("R1 ras", int'(ras), 0);
  endtask

  task automatic t_cycle();
    int n_act = 0;
    logic [ROW_W-1:0] r0 = row;
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    for (int i = 0; i < RC + 2; i++) begin
      if (active) begin
        n_act++;
        chk("R2 ras", int'(ras), (1 << NRAS) - 1);
        chk("R2 addr", int'(row), int'(r0));
      end
      @(negedge clk);
    end
    chk("R2 length", n_act, RC);
    chk("R3 step", int'(row), int'(r0) + 1);
  endtask

  task automatic t_request();
    logic [ROW_W-1:0] r0;
    @(negedge clk) rfck = 1'b1;
    repeat (3) @(negedge clk);
    rfck = 1'b0;
    chk("R4 not early", int'(oe), 0);
    @(posedge clk); #1;
    chk("R4 raised", int'(oe), 1);
    // line now low from own pull: row must hold (R8)
    r0 = row;
    repeat (3) @(posedge clk);
    #1 chk("R8 own pull", int'(row), int'(r0));
    refresh_once();
    chk("R6 withdrawn", int'(oe), 0);
    chk("R6 row", int'(row), int'(r0) + 1);
  endtask

  task automatic t_serviced();
    @(negedge clk) rfck = 1'b1;
    repeat (2) @(negedge clk);
    refresh_once();
    @(negedge clk) rfck = 1'b0;
    repeat (4) @(posedge clk);
    #1 chk("R5 no request", int'(oe), 0);
  endtask

  task automatic t_ext_clear();
    chk("R7 precond", int'(row != 0), 1);
    @(negedge clk) ext_low = 1'b1;
    @(posedge clk); #1;
    chk("R7 cleared", int'(row), 0);
    @(negedge clk) ext_low = 1'b0;
    refresh_once();
    chk("R7 resumes", int'(row), 1);
  endtask

  task automatic t_busy_go();
    logic [ROW_W-1:0] r0 = row;
    @(negedge clk) go = 1'b1;
    repeat (RC) @(negedge clk);
    go = 1'b0;
    @(posedge clk); #1;
    chk("R9 ends on time", int'(active), 0);
    chk("R9 single step", int'(row), int'(r0) + 1);
    @(posedge clk); #1;
    chk("R9 no restart", int'(active), 0);
  endtask

  task automatic t_clear_vs_step();
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    repeat (RC - 1) @(negedge clk);
    ext_low = 1'b1;
    @(posedge clk); #1;
    chk("R10 clear wins", int'(row), 0);
    chk("R10 cycle ended", int'(active), 0);
    @(negedge clk) ext_low = 1'b0;
  endtask

  task automatic t_wrap();
    @(negedge clk) ext_low = 1'b1;
    @(negedge clk) ext_low = 1'b0;
    for (int i = 0; i < (1 << ROW_W) - 1; i++) refresh_once();
    chk("R3 top", int'(row), (1 << ROW_W) - 1);
    refresh_once();
    chk("R3 wrap", int'(row), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cycle();
    t_request();
    t_serviced();
    t_ext_clear();
    t_busy_go();
    t_clear_vs_step();
    t_wrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule